// File: doc/BRIEF.md
# Program Status Word Flag Unit

This block keeps the 8-bit status word of a small 8-bit microcontroller datapath. When the datapath runs an addition, an addition with carry, a subtraction with borrow, a multiply or a divide, it presents the operation code and both operands. The unit then updates its carry, half-carry and overflow flags at the next clock edge. A parity flag follows the accumulator continuously and is never stored. Two general-purpose user flags and a two-bit bank select hold their values until software writes them.

Software reaches the status word over a special-function-register bus. A byte write and a combinational byte read both use address 0xD0. A single-bit write and a single-bit read use bit addresses 0xD0 to 0xD7, where the low three address bits select the bit. The bank select and a 3-bit working-register index together give the direct RAM address of that register. Arithmetic results themselves, instruction decode and the RAM are outside this block.

Top module: `psw_unit`

## Requirements
- R1: After reset the status word reads 0x00. A byte read at address 0xD0 returns the word, and a read at any other address returns 0x00. Bit layout from bit 7 down: carry, half-carry, user flag 0, bank select high, bank select low, overflow, user flag 1, parity.
- R2: Operation codes are 0 none, 1 add, 2 add with carry, 3 subtract with borrow, 4 multiply, 5 divide. Add and add-with-carry set carry on a carry out of bit 7 and set half-carry on a carry out of bit 3. Otherwise they clear both.
- R3: Add, add-with-carry and subtract-with-borrow set overflow on signed two's-complement overflow and clear it otherwise.
- R4: Add-with-carry uses the current carry flag as carry-in, and subtract-with-borrow uses it as borrow-in. Plain add ignores it. Subtract sets carry on a borrow out of bit 7 and sets half-carry on a borrow into bit 3.
- R5: Multiply sets overflow when the product exceeds 255 and clears it otherwise. It clears carry and leaves half-carry unchanged.
- R6: Divide sets overflow when the divisor (operand b) is zero and clears it otherwise. It clears carry and leaves half-carry unchanged.
- R7: Operation code 0 leaves carry, half-carry and overflow unchanged.
- R8: Bit 0 always equals the XOR of the eight accumulator bits. Writes to it have no effect.
- R9: The RAM address output is {3'b000, bank select, register index}. It uses the bank select held at the start of the cycle, so a bank change applies from the next cycle.
- R10: When a byte write to 0xD0 and a flag update happen in the same cycle, the written value wins for bits 7 to 1.
- R11: A bit write to address 0xD0+n sets bit n to the written value, except bit 0, which ignores the write. A bit read returns bit n. Bit writes to other addresses have no effect. A byte write in the same cycle takes priority over a bit write.
- R12: User flags 0 and 1 change only through software writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 3 | Arithmetic operation code |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand (divisor for divide) |
| acc | input | 8 | Current accumulator value |
| sfr_addr | input | 8 | Byte access address |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rdata | output | 8 | Byte read data |
| bit_addr | input | 8 | Bit access address |
| bit_wr | input | 1 | Bit write strobe |
| bit_wval | input | 1 | Bit write value |
| bit_rdata | output | 1 | Bit read data |
| reg_idx | input | 3 | Working register index |
| ram_addr | output | 8 | Direct RAM address of the working register |
| psw | output | 8 | Current status word |

## Verification
The assertions watch these behaviours on every cycle: parity tracking the accumulator, the RAM address formed from the held bank bits, byte writes taking priority, user flags staying fixed without a write, flags holding under operation code 0, and the carry and overflow results of multiply and divide. The exact carry, half-carry and overflow values for particular operand pairs appear only in the bench's vector table. The same holds for the carry-in and borrow-in taken from a preset carry, the one-cycle delay of a bank change, and the bit-address decode.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ADD  = 3'd1,
    OP_ADDC = 3'd2,
    OP_SUBB = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5
  } psw_op_e;

  localparam int B_CY  = 7;
  localparam int B_AC  = 6;
  localparam int B_UF0 = 5;
  localparam int B_BK1 = 4;
  localparam int B_BK0 = 3;
  localparam int B_OV  = 2;
  localparam int B_UF1 = 1;
  localparam int B_PAR = 0;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } arith_flags_t;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } flag_en_t;
endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/psw_flag_calc.sv
module psw_flag_calc
  import psw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [2:0]    op_code,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic          cy_cur,
  output arith_flags_t  flags,
  output flag_en_t      flag_en
);
  localparam int NW = DW / 2;

  logic          cin;
  logic [DW:0]   add_s;
  logic [DW:0]   sub_d;
  logic [NW:0]   add_n;
  logic [NW:0]   sub_n;
  logic [2*DW-1:0] prod;
  psw_op_e       op;

  always_comb begin
    op    = psw_op_e'(op_code);
    cin   = ((op == OP_ADDC) || (op == OP_SUBB)) ? cy_cur : 1'b0;
    add_s = {1'b0, opnd_a} + {1'b0, opnd_b} + {{DW{1'b0}}, cin};
    sub_d = {1'b0, opnd_a} - {1'b0, opnd_b} - {{DW{1'b0}}, cin};
    add_n = {1'b0, opnd_a[NW-1:0]} + {1'b0, opnd_b[NW-1:0]} + {{NW{1'b0}}, cin};
    sub_n = {1'b0, opnd_a[NW-1:0]} - {1'b0, opnd_b[NW-1:0]} - {{NW{1'b0}}, cin};
    prod  = {{DW{1'b0}}, opnd_a} * {{DW{1'b0}}, opnd_b};
  end

  always_comb begin
    flags   = '0;
    flag_en = '0;
    unique case (op)
      OP_ADD, OP_ADDC: begin
        flag_en  = '{cy: 1'b1, ac: 1'b1, ov: 1'b1};
        flags.cy = add_s[DW];
        flags.ac = add_n[NW];
        flags.ov = (opnd_a[DW-1] == opnd_b[DW-1]) && (add_s[DW-1] != opnd_a[DW-1]);
      end
      OP_SUBB: begin
        flag_en  = '{cy: 1'b1, ac: 1'b1, ov: 1'b1};
        flags.cy = sub_d[DW];
        flags.ac = sub_n[NW];
        flags.ov = (opnd_a[DW-1] != opnd_b[DW-1]) && (sub_d[DW-1] != opnd_a[DW-1]);
      end
      OP_MUL: begin
        flag_en  = '{cy: 1'b1, ac: 1'b0, ov: 1'b1};
        flags.ov = |prod[2*DW-1:DW];
      end
      OP_DIV: begin
        flag_en  = '{cy: 1'b1, ac: 1'b0, ov: 1'b1};
        flags.ov = (opnd_b == '0);
      end
      default: begin
        flag_en = '0;
      end
    endcase
  end
endmodule

// File: rtl/psw_parity.sv
module psw_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc,
  output logic          par
);
  assign par = ^acc;
endmodule

// File: rtl/psw_bank_map.sv
module psw_bank_map #(
  parameter int IDX_W  = 3,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 8
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD_W = ADDR_W - BANK_W - IDX_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign addr = {{PAD_W{1'b0}}, bank, idx};
    end else begin : g_nopad
      assign addr = {bank, idx};
    end
  endgenerate
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          IDX_W    = 3,
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  PSW_ADDR = 8'hD0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_code,
  input  logic [DW-1:0]     opnd_a,
  input  logic [DW-1:0]     opnd_b,
  input  logic [DW-1:0]     acc,
  input  logic [7:0]        sfr_addr,
  input  logic              sfr_wr,
  input  logic [DW-1:0]     sfr_wdata,
  output logic [DW-1:0]     sfr_rdata,
  input  logic [7:0]        bit_addr,
  input  logic              bit_wr,
  input  logic              bit_wval,
  output logic              bit_rdata,
  input  logic [IDX_W-1:0]  reg_idx,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DW-1:0]     psw
);
  localparam int BANK_W = 2;
  localparam int SEL_W  = $clog2(DW);

  logic          rst_sync_n;
  logic [DW-1:1] word_q;
  logic [DW-1:1] word_d;
  logic          word_en;
  logic          par;
  logic          byte_hit;
  logic          bit_hit;
  logic [SEL_W-1:0] bit_sel;
  arith_flags_t  flags;
  flag_en_t      flag_en;

  psw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psw_flag_calc #(.DW(DW)) u_calc (
    .op_code (op_code),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .cy_cur  (word_q[B_CY]),
    .flags   (flags),
    .flag_en (flag_en)
  );

  psw_parity #(.DW(DW)) u_par (
    .acc (acc),
    .par (par)
  );

  psw_bank_map #(.IDX_W(IDX_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_bank (
    .bank (word_q[B_BK1:B_BK0]),
    .idx  (reg_idx),
    .addr (ram_addr)
  );

  assign byte_hit = sfr_wr && (sfr_addr == PSW_ADDR);
  assign bit_hit  = bit_wr && (bit_addr[7:SEL_W] == PSW_ADDR[7:SEL_W]);
  assign bit_sel  = bit_addr[SEL_W-1:0];
  assign word_en  = byte_hit || bit_hit || (|flag_en);

  always_comb begin
    word_d = word_q;
    if (flag_en.cy) word_d[B_CY] = flags.cy;
    if (flag_en.ac) word_d[B_AC] = flags.ac;
    if (flag_en.ov) word_d[B_OV] = flags.ov;
    if (bit_hit && (bit_sel != SEL_W'(B_PAR))) word_d[bit_sel] = bit_wval;
    if (byte_hit) word_d = sfr_wdata[DW-1:1];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign psw       = {word_q, par};
  assign sfr_rdata = (sfr_addr == PSW_ADDR) ? psw : '0;
  assign bit_rdata = (bit_addr[7:SEL_W] == PSW_ADDR[7:SEL_W]) ? psw[bit_sel] : 1'b0;
endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] op_code,
  input logic [7:0] opnd_b,
  input logic [7:0] acc,
  input logic [7:0] sfr_addr,
  input logic       sfr_wr,
  input logic [7:0] sfr_wdata,
  input logic [7:0] bit_addr,
  input logic       bit_wr,
  input logic [2:0] reg_idx,
  input logic [7:0] ram_addr,
  input logic [7:0] psw
);
  logic no_wr;
  assign no_wr = !(sfr_wr && sfr_addr == 8'hD0) && !(bit_wr && bit_addr[7:3] == 5'h1A);

  always_comb begin
    if (rst_n) begin
      a_r8_parity_live: assert (psw[0] == ^acc);
      a_r9_bank_addr: assert (ram_addr == {3'b000, psw[4:3], reg_idx});
    end
  end

  a_r7_none_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd0 && no_wr) |=> ($stable(psw[7:6]) && $stable(psw[2])));

  a_r12_user_flags: assert property (@(posedge clk) disable iff (!rst_n)
    no_wr |=> ($stable(psw[5]) && $stable(psw[1])));

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == 8'hD0) |=> (psw[7:1] == $past(sfr_wdata[7:1])));

  a_r5_mul_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd4 && no_wr) |=> (!psw[7] && psw[6] == $past(psw[6])));

  a_r6_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd5 && opnd_b == 8'h00 && no_wr) |=> (psw[2] && !psw[7]));
endmodule

bind psw_unit psw_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .op_code   (op_code),
  .opnd_b    (opnd_b),
  .acc       (acc),
  .sfr_addr  (sfr_addr),
  .sfr_wr    (sfr_wr),
  .sfr_wdata (sfr_wdata),
  .bit_addr  (bit_addr),
  .bit_wr    (bit_wr),
  .reg_idx   (reg_idx),
  .ram_addr  (ram_addr),
  .psw       (psw)
);

// File: tb/sim_psw_unit.sv
module sim_psw_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] pre;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{3'd1, 8'h0F, 8'h01, 8'h00, 8'h40},  // R2 half-carry
    '{3'd1, 8'hFF, 8'h01, 8'h80, 8'hC0},  // R2/R4 carry, CY ignored
    '{3'd1, 8'h7F, 8'h01, 8'h00, 8'h44},  // R3 signed overflow
    '{3'd2, 8'h10, 8'h20, 8'h80, 8'h00},  // R4 carry-in, flags clear
    '{3'd2, 8'h0F, 8'h00, 8'h80, 8'h40},  // R4 carry-in to nibble
    '{3'd3, 8'h10, 8'h01, 8'h00, 8'h40},  // R4 nibble borrow
    '{3'd3, 8'h00, 8'h00, 8'h80, 8'hC0},  // R4 borrow-in
    '{3'd3, 8'h80, 8'h01, 8'h00, 8'h44},  // R3 subtract overflow
    '{3'd4, 8'h10, 8'h10, 8'hC0, 8'h44},  // R5 product > 255
    '{3'd4, 8'h0F, 8'h11, 8'h84, 8'h00},  // R5 product 255
    '{3'd5, 8'h05, 8'h00, 8'hC0, 8'h44},  // R6 divide by zero
    '{3'd5, 8'h05, 8'h01, 8'h04, 8'h00},  // R6 normal divide
    '{3'd0, 8'hFF, 8'hFF, 8'hE6, 8'hE6},  // R7 no operation
    '{3'd0 + 3'd1, 8'h00, 8'h00, 8'h26, 8'h22}   // R12 user flags kept
  };

  logic       clk;
  logic       rst_n;
  logic [2:0] op_code;
  logic [7:0] opnd_a, opnd_b, acc;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       sfr_wr;
  logic [7:0] bit_addr;
  logic       bit_wr, bit_wval, bit_rdata;
  logic [2:0] reg_idx;
  logic [7:0] ram_addr, psw;

  int n_cmp;
  int n_bad;
  bit done;

  psw_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .acc(acc), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .bit_addr(bit_addr), .bit_wr(bit_wr), .bit_wval(bit_wval),
    .bit_rdata(bit_rdata), .reg_idx(reg_idx), .ram_addr(ram_addr), .psw(psw)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic byte_write(input logic [7:0] v);
    @(negedge clk);
    sfr_addr = 8'hD0; sfr_wr = 1'b1; sfr_wdata = v;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; op_code = 3'd0; opnd_a = '0; opnd_b = '0; acc = '0;
    sfr_addr = 8'hD0; sfr_wr = 1'b0; sfr_wdata = '0;
    bit_addr = 8'hD0; bit_wr = 1'b0; bit_wval = 1'b0; reg_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state and byte read decode
    check("R1 reset psw", psw, 8'h00);
    check("R1 read 0xD0", sfr_rdata, 8'h00);

    // vector table for R2..R7, R12
    foreach (VEC[i]) begin
      @(negedge clk);
      sfr_addr = 8'hD0; sfr_wr = 1'b1; sfr_wdata = VEC[i].pre; op_code = 3'd0;
      @(negedge clk);
      sfr_wr = 1'b0; op_code = VEC[i].op; opnd_a = VEC[i].a; opnd_b = VEC[i].b;
      @(negedge clk);
      op_code = 3'd0;
      check($sformatf("R2-vector %0d (R3 R4 R5 R6 R7 R12)", i), psw & 8'hFE, VEC[i].exp);
    end

    // R1 read at another address
    byte_write(8'hA4);
    sfr_addr = 8'hD1;
    #1 check("R1 other address", sfr_rdata, 8'h00);
    sfr_addr = 8'hD0;
    #1 check("R1 readback", sfr_rdata, 8'hA4);

    // R8 parity live, not writable
    acc = 8'h01;
    #1 check("R8 odd parity", {7'd0, psw[0]}, 8'h01);
    acc = 8'h03;
    #1 check("R8 even parity", {7'd0, psw[0]}, 8'h00);
    byte_write(8'hFF);
    check("R8 write ignored", {7'd0, psw[0]}, 8'h00);
    acc = 8'h00;

    // R9 bank mapping and timing
    byte_write(8'h10);
    reg_idx = 3'd5;
    #1 check("R9 bank2 idx5", ram_addr, 8'h15);
    @(negedge clk);
    sfr_wr = 1'b1; sfr_wdata = 8'h18; reg_idx = 3'd1;
    #1 check("R9 old bank same cycle", ram_addr, 8'h11);
    @(negedge clk);
    sfr_wr = 1'b0;
    check("R9 new bank next cycle", ram_addr, 8'h19);

    // R10 byte write beats flag update
    @(negedge clk);
    sfr_wr = 1'b1; sfr_wdata = 8'h00; op_code = 3'd1; opnd_a = 8'hFF; opnd_b = 8'h01;
    @(negedge clk);
    sfr_wr = 1'b0; op_code = 3'd0;
    check("R10 write wins", psw, 8'h00);

    // R11 bit access
    @(negedge clk);
    bit_wr = 1'b1; bit_addr = 8'hD5; bit_wval = 1'b1;
    @(negedge clk);
    bit_addr = 8'hD0;
    @(negedge clk);
    bit_addr = 8'hC2;
    @(negedge clk);
    bit_wr = 1'b0; bit_addr = 8'hD5;
    check("R11 bit write", psw, 8'h20);
    #1 check("R11 bit read", {7'd0, bit_rdata}, 8'h01);

    finish_run();
  end
endmodule